// File: doc/BRIEF.md
# DRAM Burst-Truncation Precharge Scheduler

This block sequences one bank of a DDR-style SDRAM for requests that need fewer data beats than the fixed burst length. For each accepted request it opens the row, issues a read or write column command without auto-precharge, and then closes the row with a PRECHARGE. That PRECHARGE comes as early as the timing rules allow, so an unneeded tail of the burst is cut off. A read is cut simply by the PRECHARGE: beats whose slot falls at or after the PRECHARGE cycle never return. A write always runs every beat slot, and the unwanted tail beats are masked.

Three timing limits are runtime inputs counted in clock cycles: the minimum row-active time, the delay from the last wanted write beat to PRECHARGE, and the precharge period. They must be held constant while the block is not idle. The requester sees a ready/valid handshake, and only one request is in flight at a time. The block models one beat per clock. Read beats appear CL cycles after their slot. Write beats appear one cycle after their slot.

Top module: `burst_pre_sched`

## Requirements
- R1: `req_ready_o` is high only while idle, and `cmd_o` is NOP (0) whenever it is high. A request accepted in cycle i yields ACTIVATE (1) in cycle i+1. In cycle i+2 it yields READ (2) when `req_write_i` was 0, or WRITE (3) when it was 1. PRECHARGE is encoded 4.
- R2: A requested beat count of 0 is treated as 1. A count above BL is treated as BL.
- R3: For a read with n beats, ACTIVATE in cycle a and READ in cycle a+1, PRECHARGE (4) is issued exactly in cycle max(a+max(t_ras,1), a+1+n).
- R4: Read beat k appears on `rd_beat_o`/`rd_idx_o` in cycle READ+CL+k. Only beats whose slot READ+k precedes the PRECHARGE cycle p appear, which gives min(BL, p-READ) beats in ascending index order.
- R5: For a write with n beats, PRECHARGE is issued exactly in cycle max(a+max(t_ras,1), a+n+t_dpl+2). That is the later of the row-active limit and t_dpl+1 cycles after the last wanted write beat.
- R6: Write beat k appears on `wr_beat_o`/`wr_idx_o` in cycle WRITE+1+k for every k from 0 to BL-1, including beats that fall after the PRECHARGE.
- R7: `wr_mask_o` (1 = masked) is high on a write beat exactly when its index is at least n.
- R8: After PRECHARGE in cycle p, `req_ready_o` rises in cycle max(p+max(t_rp,1), W)+1, where W is WRITE+BL for a write and 0 for a read. No ACTIVATE is issued earlier than t_rp cycles after PRECHARGE.
- R9: A request for n = BL returns all BL read beats, or leaves every write beat unmasked, under the same timing rules.
- R10: After reset `req_ready_o` is 1, `cmd_o` is NOP, and no beat strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_beats_i | input | CW | Wanted beat count |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| t_ras_i | input | TW | Minimum row-active cycles |
| t_rp_i | input | TW | Precharge period cycles |
| t_dpl_i | input | TW | Last-write-data to precharge cycles |
| cmd_o | output | 3 | Command: NOP 0, ACT 1, RD 2, WR 3, PRE 4 |
| wr_beat_o | output | 1 | Write beat strobe |
| wr_idx_o | output | IW | Write beat index |
| wr_mask_o | output | 1 | Write beat masked |
| rd_beat_o | output | 1 | Read beat strobe |
| rd_idx_o | output | IW | Read beat index |

## Verification
The hardest condition to reach is one where the row-active limit and the beat-driven limit (read length, or write data plus t_dpl) trade places as the deciding constraint. The same sweep must also reach the case where a write PRECHARGE lands while masked beats are still streaming. The stimulus sweeps every beat count, including the out-of-range ones, against several row-active, write-delay and precharge settings for both directions. Each cut-off cycle, beat count, mask pattern and idle-return cycle is checked against closed-form expressions.

// File: rtl/burst_pre_pkg.sv
package burst_pre_pkg;
  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_ACT = 3'd1;
  localparam logic [2:0] CMD_RD  = 3'd2;
  localparam logic [2:0] CMD_WR  = 3'd3;
  localparam logic [2:0] CMD_PRE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_WAIT_PRE,
    ST_WAIT_RP
  } seq_state_e;
endpackage

// File: rtl/bps_timer.sv
module bps_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/bps_delay.sv
module bps_delay #(
  parameter int DEPTH = 1,
  parameter int W     = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= '0;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[i] <= '0;
        else         pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/bps_slot_gen.sv
// Emits one beat slot per cycle starting on the column command cycle.
// Read slots stop on the precharge cycle; write slots always run BL.
module bps_slot_gen #(
  parameter int BL = 4,
  localparam int CW = $clog2(BL + 1),
  localparam int IW = $clog2(BL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [CW-1:0] beats_i,
  input  logic          kill_i,
  output logic          slot_o,
  output logic          wr_o,
  output logic [IW-1:0] idx_o,
  output logic          mask_o,
  output logic [CW-1:0] sent_o,
  output logic          busy_o
);
  logic          busy_q, wr_q;
  logic [IW-1:0] cnt_q;
  logic [CW-1:0] n_q, sent_q, n_cur;
  logic          kill_rd;

  assign wr_o    = start_i ? write_i : wr_q;
  assign idx_o   = start_i ? '0 : cnt_q;
  assign n_cur   = start_i ? beats_i : n_q;
  assign kill_rd = kill_i & ~wr_o;
  assign slot_o  = (start_i | busy_q) & ~kill_rd;
  assign mask_o  = wr_o & (CW'(idx_o) >= n_cur);
  assign sent_o  = sent_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      sent_q <= '0;
    end else if (start_i) begin
      wr_q   <= write_i;
      n_q    <= beats_i;
      sent_q <= CW'(1);
      busy_q <= (BL > 1);
      cnt_q  <= IW'(1);
    end else if (busy_q) begin
      if (kill_rd) begin
        busy_q <= 1'b0;
      end else begin
        sent_q <= sent_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == IW'(BL - 1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_pre_sched.sv
module burst_pre_sched
  import burst_pre_pkg::*;
#(
  parameter int BL = 4,
  parameter int CL = 2,
  parameter int TW = 6,
  localparam int CW = $clog2(BL + 1),
  localparam int IW = $clog2(BL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [CW-1:0] req_beats_i,
  output logic          req_ready_o,
  input  logic [TW-1:0] t_ras_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_dpl_i,
  output logic [2:0]    cmd_o,
  output logic          wr_beat_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          wr_mask_o,
  output logic          rd_beat_o,
  output logic [IW-1:0] rd_idx_o
);
  localparam int WL  = 1;
  localparam int RDW = 1 + IW;
  localparam int WRW = 2 + IW;

  seq_state_e    state_q, state_d;
  logic          wr_q, dpl_armed_q;
  logic [CW-1:0] n_q, beats_cl;
  logic          ras_done, rp_done, dpl_done, dpl_load, pre_ok;
  logic          col_start, pre_issue;
  logic [TW-1:0] ras_val, rp_val;
  logic          slot, slot_wr, slot_mask, slot_busy;
  logic [IW-1:0] slot_idx;
  logic [CW-1:0] slot_sent;
  logic [RDW-1:0] rd_in, rd_out;
  logic [WRW-1:0] wr_in, wr_out;

  always_comb begin
    if (req_beats_i == '0)              beats_cl = CW'(1);
    else if (req_beats_i > CW'(BL))     beats_cl = CW'(BL);
    else                                beats_cl = req_beats_i;
  end

  // Timers are programmed one short so "done" marks the first legal cycle.
  assign ras_val = (t_ras_i == '0) ? '0 : t_ras_i - 1'b1;
  assign rp_val  = (t_rp_i  == '0) ? '0 : t_rp_i  - 1'b1;

  assign pre_ok = ras_done &
                  (wr_q ? (dpl_armed_q & dpl_done) : (slot_sent >= n_q));

  always_comb begin
    state_d = state_q;
    cmd_o   = CMD_NOP;
    case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_ACT;
      ST_ACT: begin
        cmd_o   = CMD_ACT;
        state_d = ST_COL;
      end
      ST_COL: begin
        cmd_o   = wr_q ? CMD_WR : CMD_RD;
        state_d = ST_WAIT_PRE;
      end
      ST_WAIT_PRE: if (pre_ok) begin
        cmd_o   = CMD_PRE;
        state_d = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (rp_done && !slot_busy) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign col_start   = (state_q == ST_COL);
  assign pre_issue   = (cmd_o == CMD_PRE);
  assign dpl_load    = wr_beat_o & (CW'(wr_idx_o) == n_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      n_q         <= CW'(1);
      dpl_armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_ready_o && req_valid_i) begin
        wr_q <= req_write_i;
        n_q  <= beats_cl;
      end
      if (col_start)     dpl_armed_q <= 1'b0;
      else if (dpl_load) dpl_armed_q <= 1'b1;
    end
  end

  bps_timer #(.TW(TW)) u_ras (
    .clk_i, .rst_ni, .load_i(state_q == ST_ACT), .val_i(ras_val), .done_o(ras_done)
  );
  bps_timer #(.TW(TW)) u_rp (
    .clk_i, .rst_ni, .load_i(pre_issue), .val_i(rp_val), .done_o(rp_done)
  );
  bps_timer #(.TW(TW)) u_dpl (
    .clk_i, .rst_ni, .load_i(dpl_load), .val_i(t_dpl_i), .done_o(dpl_done)
  );

  bps_slot_gen #(.BL(BL)) u_slots (
    .clk_i, .rst_ni,
    .start_i(col_start), .write_i(wr_q), .beats_i(n_q), .kill_i(pre_issue),
    .slot_o(slot), .wr_o(slot_wr), .idx_o(slot_idx), .mask_o(slot_mask),
    .sent_o(slot_sent), .busy_o(slot_busy)
  );

  assign rd_in = {slot & ~slot_wr, slot_idx};
  assign wr_in = {slot & slot_wr, slot_idx, slot_mask};

  bps_delay #(.DEPTH(CL), .W(RDW)) u_rd_lat (.clk_i, .rst_ni, .d_i(rd_in), .q_o(rd_out));
  bps_delay #(.DEPTH(WL), .W(WRW)) u_wr_lat (.clk_i, .rst_ni, .d_i(wr_in), .q_o(wr_out));

  assign {rd_beat_o, rd_idx_o}            = rd_out;
  assign {wr_beat_o, wr_idx_o, wr_mask_o} = wr_out;
endmodule

// File: rtl/burst_pre_chk.sv
module burst_pre_chk
  import burst_pre_pkg::*;
#(
  parameter int TW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic          req_ready_o,
  input logic [TW-1:0] t_ras_i,
  input logic [TW-1:0] t_rp_i,
  input logic [TW-1:0] t_dpl_i,
  input logic [2:0]    cmd_o,
  input logic          wr_beat_o,
  input logic          wr_mask_o
);
  localparam int SW = TW + 2;
  logic [SW-1:0] since_act, since_pre, since_wd;
  logic [TW-1:0] ras_q, rp_q;
  logic          wr_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '1;
      since_pre <= '1;
      since_wd  <= '1;
      ras_q     <= '0;
      rp_q      <= '0;
      wr_op_q   <= 1'b0;
    end else begin
      if (cmd_o == CMD_ACT) begin
        since_act <= SW'(1);
        ras_q     <= t_ras_i;
      end else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd_o == CMD_PRE) begin
        since_pre <= SW'(1);
        rp_q      <= t_rp_i;
      end else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      if (wr_beat_o && !wr_mask_o) since_wd <= SW'(1);
      else if (since_wd != '1)     since_wd <= since_wd + 1'b1;
      if (req_valid_i && req_ready_o) wr_op_q <= req_write_i;
    end
  end

  // R1
  ready_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cmd_o == CMD_NOP);
  // R1
  act_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> cmd_o == CMD_ACT);
  // R1
  col_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |=> (cmd_o == CMD_RD || cmd_o == CMD_WR));
  // R3
  tras_met_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |-> since_act >= SW'(ras_q));
  // R5
  tdpl_met_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE && wr_op_q) |-> since_wd > SW'(t_dpl_i));
  // R8
  trp_met_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> since_pre >= SW'(rp_q));
  // R7
  mask_on_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_o |-> wr_beat_o);
endmodule

bind burst_pre_sched burst_pre_chk #(.TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_ready_o(req_ready_o), .t_ras_i(t_ras_i),
  .t_rp_i(t_rp_i), .t_dpl_i(t_dpl_i), .cmd_o(cmd_o), .wr_beat_o(wr_beat_o),
  .wr_mask_o(wr_mask_o)
);

// File: tb/burst_pre_sched_test.sv
module burst_pre_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 4;
  localparam int CL = 2;
  localparam int TW = 6;
  localparam int CW = $clog2(BL + 1);
  localparam int IW = $clog2(BL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [CW-1:0] req_beats = '0;
  logic          req_ready;
  logic [TW-1:0] t_ras = '0, t_rp = '0, t_dpl = '0;
  logic [2:0]    cmd;
  logic          wr_beat, wr_mask, rd_beat;
  logic [IW-1:0] wr_idx, rd_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_pre_sched #(.BL(BL), .CL(CL), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_beats_i(req_beats), .req_ready_o(req_ready), .t_ras_i(t_ras),
    .t_rp_i(t_rp), .t_dpl_i(t_dpl), .cmd_o(cmd), .wr_beat_o(wr_beat),
    .wr_idx_o(wr_idx), .wr_mask_o(wr_mask), .rd_beat_o(rd_beat), .rd_idx_o(rd_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_op(input bit wr, input int nraw, input int tras,
                        input int tdpl, input int trp);
    int n, exp_p, exp_rd, exp_rdy, pre_cnt, pre_at, rd_seen, wr_seen, rdy_at;
    n = (nraw == 0) ? 1 : ((nraw > BL) ? BL : nraw);              // R2
    exp_p = wr ? imax(1 + imax(tras, 1), 3 + n + tdpl)             // R5
               : imax(1 + imax(tras, 1), 2 + n);                   // R3
    exp_rd = wr ? 0 : ((exp_p - 2 < BL) ? exp_p - 2 : BL);
    exp_rdy = imax(exp_p + imax(trp, 1), wr ? 2 + BL : 0) + 1;     // R8
    while (!req_ready) @(negedge clk);
    t_ras = TW'(tras); t_dpl = TW'(tdpl); t_rp = TW'(trp);
    req_valid = 1'b1; req_write = wr; req_beats = CW'(nraw);
    @(negedge clk);
    req_valid = 1'b0;
    pre_cnt = 0; pre_at = -1; rd_seen = 0; wr_seen = 0; rdy_at = -1;
    for (int cyc = 1; cyc < 200; cyc++) begin
      if (cyc == 1) check(cmd == 3'd1, "R1 activate", cmd, 1);
      if (cyc == 2) check(cmd == (wr ? 3'd3 : 3'd2), "R1 column", cmd, wr ? 3 : 2);
      if (cmd == 3'd4) begin pre_cnt++; pre_at = cyc; end
      if (rd_beat) begin
        check(cyc == 2 + CL + rd_seen && rd_idx == IW'(rd_seen), "R4 read beat cycle",
              cyc, 2 + CL + rd_seen);
        rd_seen++;
      end
      if (wr_beat) begin
        check(cyc == 3 + wr_seen && wr_idx == IW'(wr_seen), "R6 write beat cycle",
              cyc, 3 + wr_seen);
        check(wr_mask == (wr_seen >= n), "R7 mask", wr_mask, wr_seen >= n);
        wr_seen++;
      end
      if (req_ready) begin rdy_at = cyc; break; end
      @(negedge clk);
    end
    check(pre_cnt == 1, "R3/R5 single precharge", pre_cnt, 1);
    check(pre_at == exp_p, wr ? "R5 write precharge cycle" : "R3 read precharge cycle",
          pre_at, exp_p);
    check(rd_seen == exp_rd, "R4 read beats returned", rd_seen, exp_rd);
    check(wr_seen == (wr ? BL : 0), "R6 write beats driven", wr_seen, wr ? BL : 0);
    check(rdy_at == exp_rdy, "R8 ready return", rdy_at, exp_rdy);
    if (n == BL) check(wr ? (wr_seen == BL) : (rd_seen == BL), "R9 full burst",
                       wr ? wr_seen : rd_seen, BL);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ras_set[3] = '{0, 3, 9};
    int dpl_set[3] = '{0, 1, 3};
    int rp_set[3]  = '{0, 1, 4};
    repeat (3) @(negedge clk);
    // R10
    check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    check(cmd == 3'd0, "R10 reset command", cmd, 0);
    check(!rd_beat && !wr_beat, "R10 reset beats", rd_beat | wr_beat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 2; w++)
      for (int n = 0; n <= 6; n++)
        for (int a = 0; a < 3; a++)
          for (int d = 0; d < 3; d++)
            for (int r = 0; r < 3; r++)
              run_op(w[0], n, ras_set[a], dpl_set[d], rp_set[r]);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule